// File: doc/BRIEF.md
# Staged PLL Bring-Up Sequencer

This block is a hardware sequencer that brings a three-level PLL chain out of reset after a single start pulse. The first level is a spread-spectrum PLL. The second is a pair of filter PLLs. The last is a tank PLL. The sequencer owns two 64-bit control words, called word A and word B. These words hold the reset, bypass and test-enable controls of the chain. The sequencer releases the controls one step at a time. After each reset release it waits a fixed settle interval and then samples four lock flags.

If a stage fails to lock, the sequence stops at once and reports an error code that names the stage. It also keeps a copy of the lock flags it sampled and changes no more control bits. If every stage locks, the sequencer removes the last bypass and raises done. A strap input chooses whether the memory clock mesh is switched onto the nest clock. This switch sets one clock-input-select bit in word A. The settle interval is a parameter, computed either from the clock frequency and a time in microseconds or from a short cycle count meant for simulation.

Top module: `pll_bringup_seq`

## Requirements
- R1: During and after reset, ctrl_a_o equals A_INIT (default 64'hCF28_0000_0000_0000) and ctrl_b_o equals B_INIT (default 64'h0C00_0000_0000_0000). busy_o, done_o, err_o and lock_snap_o are all zero. Control bits are numbered from the MSB, so bit n is vector index 63-n.
- R2: A start_i pulse in idle reloads both words with their init values and raises busy_o on the next cycle. A run with every lock present keeps busy_o high for exactly 6+3*T cycles, where T is the settle count.
- R3: A fully locked run ends with done_o=1, err_o=0 and lock_snap_o=4'b1111. Word A then has bits 0, 1, 4, 5, 6, 7, 10 and 12 cleared. Word B has bits 4 and 5 cleared. Every other bit keeps its init value, except for bit 31 of word A (see R4).
- R4: Bit 31 of word A is set only when sync_mode_i=1 at the point where the filter bypasses have been removed. Otherwise it keeps its init value.
- R5: If lock_i[0] (spread-spectrum lock) is clear after the first settle, err_o=1 and busy_o lasts 2+T cycles. Only bits 12 and 0 of word A are cleared.
- R6: If lock_i[1] or lock_i[2] (the filter locks) is clear after the second settle, err_o=2 and busy_o lasts 3+2*T cycles. Only bits 12, 0, 1 and 4 of word A are cleared.
- R7: If lock_i[3] (nest lock) is clear after the third settle, err_o=3 and busy_o lasts 6+3*T cycles. Bit 4 of word B is cleared and bit 5 of word B stays set. Word A is as in R3 and R4.
- R8: At every lock check, lock_snap_o captures lock_i as it was sampled. After an abort, it holds the sample that failed.
- R9: done_o and a nonzero err_o never appear together, and neither appears while busy_o=1. Both flags and both words hold their values in idle until the next start_i. The next start_i clears the flags on the cycle busy_o rises.
- R10: A start_i pulse while busy_o=1 is ignored: it does not reload the words and does not change the run length.
- R11: Bit 4 of word B (tank reset) is never clear unless bits 5, 6 and 7 of word A (filter bypasses) are already clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled only in idle |
| sync_mode_i | input | 1 | Strap that requests the clock-input mux switch |
| lock_i | input | 4 | Lock flags: [0] spread-spectrum, [1],[2] filters, [3] nest |
| ctrl_a_o | output | 64 | Control word A (MSB-first bit numbering) |
| ctrl_b_o | output | 64 | Control word B (MSB-first bit numbering) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Chain fully brought up |
| err_o | output | 2 | 0 none, 1 spread-spectrum, 2 filter, 3 nest |
| lock_snap_o | output | 4 | Lock flags captured at the latest check |

## Verification
The bench builds the block with FAST_SIM=1 and SIM_CYCLES=9, so each settle is nine cycles and a full run lasts 33 cycles. This makes exact run-length checks practical for all three abort points and for the full run, across dozens of lock and strap combinations. The 250 MHz default settle of 25000 cycles is covered only by the same formula, not by a run.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TEST_OFF,
        ST_SS_REL,
        ST_SS_WAIT,
        ST_FL_REL,
        ST_FL_WAIT,
        ST_MUX,
        ST_TK_TBYP,
        ST_TK_REL,
        ST_TK_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SS   = 2'd1,
        ERR_FILT = 2'd2,
        ERR_NEST = 2'd3
    } seq_err_e;

    // control bit numbers, MSB-first
    localparam int A_TEST_EN  = 12;
    localparam int A_SS_RST   = 0;
    localparam int A_SS_BYP   = 1;
    localparam int A_FL_RST   = 4;
    localparam int A_FL_BYP   = 5;
    localparam int A_CP_ALT   = 6;
    localparam int A_IO_ALT   = 7;
    localparam int A_TK_TBYP  = 10;
    localparam int A_CLK_SEL  = 31;
    localparam int B_TK_RST   = 4;
    localparam int B_TK_BYP   = 5;

    localparam int NSTAGE = 3;
    localparam int LOCK_W = 4;

    function automatic int vidx(input int width, input int bitno);
        return width - 1 - bitno;
    endfunction

    // lock flags required by each stage: 0 spread, 1 filter pair, 2 nest
    function automatic logic [LOCK_W-1:0] stage_mask(input int stage);
        case (stage)
            0:       return 4'b0001;
            1:       return 4'b0110;
            default: return 4'b1000;
        endcase
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int TERM = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int CW = $clog2(TERM + 1);
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);

    logic          run_d, run_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (start_i) begin
            run_d = 1'b1;
            cnt_d = '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_d = 1'b0;
            else               cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_q && (cnt_q == LAST);
endmodule

// File: rtl/pll_seq_lockchk.sv
module pll_seq_lockchk
    import pll_seq_pkg::*;
(
    input  logic [LOCK_W-1:0] lock_i,
    output logic [NSTAGE-1:0] ok_o
);
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        localparam logic [LOCK_W-1:0] MASK = stage_mask(s);
        assign ok_o[s] = ((lock_i & MASK) == MASK);
    end
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter int              REG_W      = 64,
    parameter int              CLK_MHZ    = 250,
    parameter int              SETTLE_US  = 100,
    parameter bit              FAST_SIM   = 1'b0,
    parameter int              SIM_CYCLES = 1000,
    parameter logic [REG_W-1:0] A_INIT    = 64'hCF28_0000_0000_0000,
    parameter logic [REG_W-1:0] B_INIT    = 64'h0C00_0000_0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sync_mode_i,
    input  logic [3:0]       lock_i,
    output logic [REG_W-1:0] ctrl_a_o,
    output logic [REG_W-1:0] ctrl_b_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       err_o,
    output logic [3:0]       lock_snap_o
);
    localparam int TERM = FAST_SIM ? SIM_CYCLES : CLK_MHZ * SETTLE_US;

    localparam int IA_TEST = vidx(REG_W, A_TEST_EN);
    localparam int IA_SSR  = vidx(REG_W, A_SS_RST);
    localparam int IA_SSB  = vidx(REG_W, A_SS_BYP);
    localparam int IA_FLR  = vidx(REG_W, A_FL_RST);
    localparam int IA_FLB  = vidx(REG_W, A_FL_BYP);
    localparam int IA_CPA  = vidx(REG_W, A_CP_ALT);
    localparam int IA_IOA  = vidx(REG_W, A_IO_ALT);
    localparam int IA_TKT  = vidx(REG_W, A_TK_TBYP);
    localparam int IA_SEL  = vidx(REG_W, A_CLK_SEL);
    localparam int IB_TKR  = vidx(REG_W, B_TK_RST);
    localparam int IB_TKB  = vidx(REG_W, B_TK_BYP);

    typedef struct packed {
        seq_state_e       st;
        logic [REG_W-1:0] a;
        logic [REG_W-1:0] b;
        logic             done;
        seq_err_e         err;
        logic [LOCK_W-1:0] snap;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic              tmr_go;
    logic              tmr_exp;
    logic [NSTAGE-1:0] stage_ok;

    pll_seq_timer #(.TERM(TERM)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_go),
        .expired_o (tmr_exp)
    );

    pll_seq_lockchk u_lockchk (
        .lock_i (lock_i),
        .ok_o   (stage_ok)
    );

    always_comb begin
        r_d    = r_q;
        tmr_go = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.a    = A_INIT;
                    r_d.b    = B_INIT;
                    r_d.done = 1'b0;
                    r_d.err  = ERR_NONE;
                    r_d.snap = '0;
                    r_d.st   = ST_TEST_OFF;
                end
            end
            ST_TEST_OFF: begin
                r_d.a[IA_TEST] = 1'b0;
                r_d.st         = ST_SS_REL;
            end
            ST_SS_REL: begin
                r_d.a[IA_SSR] = 1'b0;
                tmr_go        = 1'b1;
                r_d.st        = ST_SS_WAIT;
            end
            ST_SS_WAIT: begin
                if (tmr_exp) begin
                    r_d.snap = lock_i;
                    if (stage_ok[0]) begin
                        r_d.a[IA_SSB] = 1'b0;
                        r_d.st        = ST_FL_REL;
                    end else begin
                        r_d.err = ERR_SS;
                        r_d.st  = ST_IDLE;
                    end
                end
            end
            ST_FL_REL: begin
                r_d.a[IA_FLR] = 1'b0;
                tmr_go        = 1'b1;
                r_d.st        = ST_FL_WAIT;
            end
            ST_FL_WAIT: begin
                if (tmr_exp) begin
                    r_d.snap = lock_i;
                    if (stage_ok[1]) begin
                        r_d.a[IA_FLB] = 1'b0;
                        r_d.a[IA_CPA] = 1'b0;
                        r_d.a[IA_IOA] = 1'b0;
                        r_d.st        = ST_MUX;
                    end else begin
                        r_d.err = ERR_FILT;
                        r_d.st  = ST_IDLE;
                    end
                end
            end
            ST_MUX: begin
                if (sync_mode_i) r_d.a[IA_SEL] = 1'b1;
                r_d.st = ST_TK_TBYP;
            end
            ST_TK_TBYP: begin
                r_d.a[IA_TKT] = 1'b0;
                r_d.st        = ST_TK_REL;
            end
            ST_TK_REL: begin
                r_d.b[IB_TKR] = 1'b0;
                tmr_go        = 1'b1;
                r_d.st        = ST_TK_WAIT;
            end
            ST_TK_WAIT: begin
                if (tmr_exp) begin
                    r_d.snap = lock_i;
                    if (stage_ok[2]) begin
                        r_d.b[IB_TKB] = 1'b0;
                        r_d.done      = 1'b1;
                    end else begin
                        r_d.err = ERR_NEST;
                    end
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.a    <= A_INIT;
            r_q.b    <= B_INIT;
            r_q.done <= 1'b0;
            r_q.err  <= ERR_NONE;
            r_q.snap <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_a_o    = r_q.a;
    assign ctrl_b_o    = r_q.b;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign lock_snap_o = r_q.snap;
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk
    import pll_seq_pkg::*;
#(
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sync_mode_i,
    input logic [3:0]       lock_i,
    input logic [REG_W-1:0] ctrl_a_o,
    input logic [REG_W-1:0] ctrl_b_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [1:0]       err_o,
    input logic [3:0]       lock_snap_o
);
    localparam int CA5 = vidx(REG_W, A_FL_BYP);
    localparam int CA6 = vidx(REG_W, A_CP_ALT);
    localparam int CA7 = vidx(REG_W, A_IO_ALT);
    localparam int CB4 = vidx(REG_W, B_TK_RST);

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o == 2'd0));

    // R9
    busy_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!done_o && err_o == 2'd0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> ($stable(ctrl_a_o) && $stable(ctrl_b_o)));

    // R11
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_b_o[CB4] |-> (!ctrl_a_o[CA5] && !ctrl_a_o[CA6] && !ctrl_a_o[CA7]));

    // R5
    ss_err_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o == 2'd1) |-> !lock_snap_o[0]);

    // R7
    nest_err_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o == 2'd3) |-> (lock_snap_o == 4'b0111));

    // R3
    done_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lock_snap_o == 4'b1111));
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_pll_bringup_seq.sv
module tb_pll_bringup_seq;
    localparam int T = 9;
    localparam logic [63:0] AI = 64'hCF28_0000_0000_0000;
    localparam logic [63:0] BI = 64'h0C00_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sync_mode_i = 1'b0;
    logic [3:0]  lock_i = 4'h0;
    logic [63:0] ctrl_a_o, ctrl_b_o;
    logic        busy_o, done_o;
    logic [1:0]  err_o;
    logic [3:0]  lock_snap_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pll_bringup_seq #(.FAST_SIM(1'b1), .SIM_CYCLES(T)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sync_mode_i(sync_mode_i),
        .lock_i(lock_i), .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .lock_snap_o(lock_snap_o)
    );

    function automatic logic [63:0] clr(input logic [63:0] v, input int b);
        logic [63:0] r = v;
        r[63-b] = 1'b0;
        return r;
    endfunction

    function automatic logic [1:0] exp_err(input logic [3:0] l);
        if (!l[0])            return 2'd1;
        if (!(l[1] && l[2]))  return 2'd2;
        if (!l[3])            return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [63:0] exp_a(input logic [3:0] l, input logic s);
        logic [1:0]  e = exp_err(l);
        logic [63:0] a = clr(clr(AI, 12), 0);
        if (e != 2'd1) a = clr(clr(a, 1), 4);
        if (e == 2'd0 || e == 2'd3) begin
            a = clr(clr(clr(a, 5), 6), 7);
            if (s) a[63-31] = 1'b1;
            a = clr(a, 10);
        end
        return a;
    endfunction

    function automatic logic [63:0] exp_b(input logic [3:0] l);
        logic [1:0]  e = exp_err(l);
        logic [63:0] b = BI;
        if (e == 2'd0 || e == 2'd3) b = clr(b, 4);
        if (e == 2'd0) b = clr(b, 5);
        return b;
    endfunction

    function automatic int exp_len(input logic [3:0] l);
        case (exp_err(l))
            2'd1:    return 2 + T;
            2'd2:    return 3 + 2 * T;
            default: return 6 + 3 * T;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one full run; inject a second start while busy when poke is set
    task automatic run(input logic [3:0] l, input logic s, input bit poke, input string req);
        int cnt = 0;
        logic [1:0] e = exp_err(l);
        lock_i = l;
        sync_mode_i = s;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "flags clear at start", {62'd0, done_o, |err_o}, 64'd0);
        while (busy_o && cnt < 500) begin
            cnt++;
            start_i = (poke && cnt == 5);
            @(negedge clk);
        end
        start_i = 1'b0;
        check(req, "busy length", 64'(cnt), 64'(exp_len(l)));
        check(req, "err code", {62'd0, err_o}, {62'd0, e});
        check(req, "done", {63'd0, done_o}, {63'd0, (e == 2'd0)});
        check(req, "word A", ctrl_a_o, exp_a(l, s));
        check(req, "word B", ctrl_b_o, exp_b(l));
        check("R8", "lock snapshot", {60'd0, lock_snap_o}, {60'd0, l});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset word A", ctrl_a_o, AI);
        check("R1", "reset word B", ctrl_b_o, BI);
        check("R1", "reset flags", {58'd0, busy_o, done_o, err_o, lock_snap_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "word A after release", ctrl_a_o, AI);

        // directed corners
        run(4'b1111, 1'b0, 1'b0, "R2 R3");
        run(4'b1111, 1'b1, 1'b0, "R4");
        run(4'b1110, 1'b1, 1'b0, "R5");
        run(4'b1011, 1'b0, 1'b0, "R6");
        run(4'b1101, 1'b1, 1'b0, "R6");
        run(4'b0111, 1'b1, 1'b0, "R7");
        run(4'b1111, 1'b0, 1'b1, "R10");
        run(4'b0111, 1'b0, 1'b1, "R10");

        // R9: flags and words hold in idle
        begin
            logic [63:0] ha = ctrl_a_o;
            lock_i = 4'h0;
            repeat (20) @(negedge clk);
            check("R9", "word A held in idle", ctrl_a_o, ha);
            check("R9", "err held in idle", {62'd0, err_o}, 64'd3);
        end

        // constrained random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 40; i++) begin
            logic [3:0] l = 4'($urandom);
            logic       s = 1'($urandom);
            if (($urandom % 3) == 0) l = 4'b1111;
            run(l, s, ($urandom % 4) == 0, "R2..random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule